// File: doc/BRIEF.md
# Board Status and Control Registers

This block is a small register window on a simple 32-bit bus with an address, a read strobe, a write strobe, write data and registered read data. It gives software a fixed build-identification word, the processor clock frequency as a constant set at build time, a readable and writable LED register that drives LED pins, and a read-only view of the DIP switches.

One offset is a write-only trigger. A write of one exact magic value there raises a one-cycle board reset request, and any other value written there is dropped. The switch inputs are asynchronous to the bus clock, so they pass through a two-flop synchronizer before a read can see them.

Read data is captured on the clock edge that samples the read strobe. It holds its value until the next read. Only word-aligned accesses are decoded, and the low two address bits are ignored.

Top module: `board_ctrl_regs`

## Requirements
- R1: While reset is asserted and just after it is released, `led_o`, `reset_req_o` and `bus_rdata` are all zero. A reset applied after the LED register was written clears it to zero.
- R2: A read at word offset 0x0 returns 0x09272011 on `bus_rdata`, valid in the cycle after the clock edge that samples `bus_rd`.
- R3: A read at offset 0x4 returns the parameter `CLK_HZ`, which defaults to 10,000,000 (0x00989680).
- R4: A write at offset 0x8 stores the low `LED_W` bits of the write data. They appear on `led_o` after the sampling edge. A read at 0x8 returns them zero-extended, with bit value 1 meaning on.
- R5: A read at offset 0xC returns the synchronized switch state, zero-extended. A switch change is seen by a read sampled on the third rising edge after the change, and not by one sampled on the first.
- R6: A write of exactly 0x0000DEAD at offset 0x10 drives `reset_req_o` high for exactly the one cycle after the sampling edge.
- R7: A write of any other value at offset 0x10 leaves `reset_req_o` low. A write of 0x0000DEAD at any other offset also leaves it low.
- R8: Reads of unlisted offsets (0x14 and above, for example) return zero. Writes to unlisted offsets, to 0xC or to read-only offsets leave `led_o` unchanged.
- R9: Address bits [1:0] are ignored, so offset 0xB accesses the LED register and offset 0x2 accesses the build word.
- R10: `bus_rdata` holds the last read value through cycles without a read strobe, including cycles that carry writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte address within the 64 KiB window |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sw_i | input | SW_W (8) | Asynchronous DIP switch inputs, 1 means on |
| led_o | output | LED_W (8) | LED drive, 1 means on |
| reset_req_o | output | 1 | One-cycle board reset request |

## Verification
A corrupted LED register shows on `led_o` in the very next cycle, and in any later read at 0x8. A stuck or leaky reset-request flop shows up as a pulse that is missing, one that lasts two cycles, or one that follows a near-miss value such as 0x0001DEAD. The bench probes each of those cases in the cycle right after the write. Faults in the synchronizer depth or in the read mux show up in the first read after the stimulus, because every read returns one cycle after its strobe.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [2:0] {
    SEL_BUILD,
    SEL_FREQ,
    SEL_LED,
    SEL_SW,
    SEL_RST,
    SEL_NONE
  } reg_sel_e;

  localparam logic [31:0] RESET_MAGIC = 32'h0000_DEAD;

  // Map a word index (byte address divided by four) onto a register.
  function automatic reg_sel_e sel_of(input logic [31:0] word_idx);
    case (word_idx)
      32'd0:   return SEL_BUILD;
      32'd1:   return SEL_FREQ;
      32'd2:   return SEL_LED;
      32'd3:   return SEL_SW;
      32'd4:   return SEL_RST;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_magic(input logic [31:0] value);
    return value == RESET_MAGIC;
  endfunction

endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output reg_sel_e          sel,
  output logic              wr_led,
  output logic              wr_magic
);
  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  always_comb begin
    sel      = sel_of(32'(addr[ADDR_W-1:2]));
    wr_led   = wr && (sel == SEL_LED);
    wr_magic = wr && (sel == SEL_RST) && is_magic(32'(wdata));
  end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bsc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          LED_W      = 8,
  parameter int          SW_W       = 8,
  parameter logic [31:0] CLK_HZ     = 32'd10_000_000,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   sw_i,
  output logic [LED_W-1:0]  led_o,
  output logic              reset_req_o
);
  reg_sel_e          sel;
  logic              wr_led;
  logic              wr_magic;
  logic [SW_W-1:0]   sw_sync;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              req_q;

  bsc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .sel      (sel),
    .wr_led   (wr_led),
    .wr_magic (wr_magic)
  );

  bsc_sync #(.W(SW_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sw_i),
    .sync_o  (sw_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= '0;
    else if (wr_led) led_q <= bus_wdata[LED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= wr_magic;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_BUILD: rd_mux = DATA_W'(BUILD_CODE);
      SEL_FREQ:  rd_mux = DATA_W'(CLK_HZ);
      SEL_LED:   rd_mux[LED_W-1:0] = led_q;
      SEL_SW:    rd_mux[SW_W-1:0]  = sw_sync;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata   = rdata_q;
  assign led_o       = led_q;
  assign reset_req_o = req_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LED_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LED_W-1:0]  led_o,
  input logic              reset_req_o,
  input logic              wr_magic
);
  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  assert_build_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == '0) |=> (bus_rdata == DATA_W'(32'h0927_2011)));

  assert_led_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == (ADDR_W-2)'(2)) |=> (led_o == $past(bus_wdata[LED_W-1:0])));

  assert_magic_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_magic |=> reset_req_o);

  assert_no_stray_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> ($past(bus_wr) && $past(widx) == (ADDR_W-2)'(4)
                     && $past(bus_wdata) == DATA_W'(32'h0000_DEAD)));

  assert_led_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(led_o));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind board_ctrl_regs bsc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .led_o       (led_o),
  .reset_req_o (reset_req_o),
  .wr_magic    (wr_magic)
);

// File: tb/board_ctrl_regs_tb_top.sv
module board_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  sw_i = '0;
  logic [7:0]  led_o;
  logic        reset_req_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  board_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sw_i(sw_i), .led_o(led_o), .reset_req_o(reset_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Returns at the negedge following the sampling edge.
  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    check("R1 led at reset", 32'(led_o), 0);
    check("R1 req at reset", 32'(reset_req_o), 0);
    check("R1 rdata at reset", bus_rdata, 0);
    bus_write(16'h0008, 32'h0000_00C3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 led cleared by reset", 32'(led_o), 0);
  endtask

  task automatic t_consts;
    logic [31:0] d;
    bus_read(16'h0000, d); check("R2 build word", d, 32'h0927_2011);
    bus_read(16'h0004, d); check("R3 clock freq", d, 32'd10_000_000);
  endtask

  task automatic t_led;
    logic [31:0] d;
    bus_write(16'h0008, 32'hFFFF_FF5A);
    check("R4 led pins", 32'(led_o), 32'h5A);
    bus_read(16'h0008, d); check("R4 led readback", d, 32'h5A);
    bus_write(16'h0008, 32'h0000_0081);
    check("R4 led pins second", 32'(led_o), 32'h81);
  endtask

  task automatic t_switch;
    logic [31:0] d;
    @(negedge clk); sw_i = 8'hA5;
    repeat (3) @(negedge clk);
    bus_read(16'h000C, d); check("R5 switches", d, 32'hA5);
    @(negedge clk);
    sw_i = 8'h3C; bus_addr = 16'h000C; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R5 switch not seen on first edge", bus_rdata, 32'hA5);
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R5 switch seen on third edge", bus_rdata, 32'h3C);
    bus_write(16'h000C, 32'h0000_00FF);
    check("R8 write to switch offset keeps led", 32'(led_o), 32'h81);
    bus_read(16'h000C, d); check("R5 switches unchanged by write", d, 32'h3C);
  endtask

  task automatic t_magic;
    bus_write(16'h0010, 32'h0000_DEAD);
    check("R6 reset request high", 32'(reset_req_o), 1);
    @(negedge clk);
    check("R6 reset request one cycle", 32'(reset_req_o), 0);
  endtask

  task automatic t_bad_magic;
    bus_write(16'h0010, 32'h0001_DEAD);
    check("R7 near-miss upper bits", 32'(reset_req_o), 0);
    bus_write(16'h0010, 32'h0000_DEAE);
    check("R7 near-miss low bits", 32'(reset_req_o), 0);
    bus_write(16'h0014, 32'h0000_DEAD);
    check("R7 magic at wrong offset", 32'(reset_req_o), 0);
    bus_write(16'h0008, 32'h0000_DEAD);
    check("R7 magic into led offset", 32'(reset_req_o), 0);
    check("R4 led takes low byte", 32'(led_o), 32'hAD);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_read(16'h0014, d); check("R8 unlisted read 0x14", d, 0);
    bus_read(16'hFFFC, d); check("R8 unlisted read 0xFFFC", d, 0);
    bus_write(16'h0100, 32'h0000_0011);
    check("R8 unlisted write keeps led", 32'(led_o), 32'hAD);
    bus_write(16'h0000, 32'h0000_0022);
    check("R8 write to build word keeps led", 32'(led_o), 32'hAD);
    bus_read(16'h0000, d); check("R8 build word unchanged", d, 32'h0927_2011);
  endtask

  task automatic t_lowbits;
    logic [31:0] d;
    bus_write(16'h000B, 32'h0000_0066);
    check("R9 offset 0xB writes led", 32'(led_o), 32'h66);
    bus_read(16'h000A, d); check("R9 offset 0xA reads led", d, 32'h66);
    bus_read(16'h0002, d); check("R9 offset 0x2 reads build", d, 32'h0927_2011);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    bus_read(16'h0004, d);
    bus_write(16'h0008, 32'h0000_0099);
    repeat (3) @(negedge clk);
    check("R10 rdata held across write and idle", bus_rdata, 32'd10_000_000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_consts();
    t_led();
    t_switch();
    t_magic();
    t_bad_magic();
    t_unmapped();
    t_lowbits();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule